// File: doc/BRIEF.md
# Six-Channel Multi-Mode PWM Duty Bank

This block holds six 8-bit duty values and turns them into six pulse-width modulated outputs. A shared counter advances only on cycles where the `tick` enable is high. The prescaler that produces `tick` sits outside the block. The counter's period and the way each output compares against it depend on a two-bit mode input. Software-side logic writes duty values through a plain write port and reads them back through a registered read port.

The block has three modes:
- **Single-pulse mode:** each channel gives one high pulse per 255-tick cycle.
- **Paired mode:** neighbouring registers form a 16-bit duty over a 65535-tick cycle, so three outputs are active.
- **Division mode:** a 256-tick period is split into sixteen 16-tick slots. Each slot carries a basic pulse set by the duty's upper nibble. The lower nibble says how many slots get one extra high tick, and those slots are picked in bit-reversed order so they are spread evenly.

Duty changes are staged and only reach the comparators at a period boundary, so a pulse is never cut short or doubled mid-cycle.

Top module: `pwm_bank`

## Requirements
- R1: The six duty registers (addresses 0 to 5) are 8 bits wide and reset to 0x00. `rd_data` returns the staged value at `rd_addr` one clock after it is presented. Writes to addresses 6 and 7 are ignored, and reads there return 0x00.
- R2: Mode encoding is 0 for single-pulse, 1 for paired 16-bit and 2 for division. Mode 3 behaves as mode 0.
- R3: In single-pulse mode the counter runs 0..254. Output k is high for counts below its duty m, so m=0 is constant low and m=255 is constant high, giving m high ticks per 255.
- R4: In paired mode the counter runs 0..65534. Even output 2j is high for counts below {reg 2j+1, reg 2j}, with the odd register as the high byte. Odd outputs stay low.
- R5: In division mode the period is 256 ticks, made of 16 slots of 16 ticks. In slot s the output is high for the first H+e ticks, where H is the upper nibble, and e=1 when the 4-bit reversal of s is less than the lower nibble (otherwise e=0). This gives 16·H+L high ticks per period.
- R6: A duty write reaches the comparators only at the next period boundary. The period in progress keeps the old duty.
- R7: In paired mode, a write to an even address goes to a holding byte per pair and leaves the staged value unchanged. A write to the odd address then commits both bytes together.
- R8: While `tick` is low the counter and all outputs hold their values.
- R9: A change of `mode` restarts the counter at 0, loads all staged duties at once and drives every output low for that clock. The output for count c appears on the clock edge after the tick that consumes count c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from an external prescaler |
| mode | input | 2 | Duty mode select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| pwm_out | output | 6 | Registered PWM outputs |

## Verification
The bench drives duty extremes 0, 1, 254 and 255 in single-pulse mode. A comparator that is off by one, or that wraps at 255 instead of 254, shows up there as one missing or extra high tick per period. In division mode it checks every slot of the pattern 0x53. A design that spread the extra ticks linearly instead of bit-reversed would stretch slots 0 to 2 rather than slots 0, 8 and 4.

Three further checks cover the staging and update rules:
- A mid-period write must not change the current period. A design that bypassed the staging register would go high straight away.
- A lone low-byte write in paired mode must not show in readback before the high byte arrives.
- While `tick` is low the outputs must not move, and a design that ignored the enable would keep toggling them.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PAIR   = 2'd1,
    MODE_DIV    = 2'd2,
    MODE_RSVD   = 2'd3
  } pwm_mode_e;
endpackage

// File: rtl/pwm_duty_regs.sv
// Staged duty registers, pair holding bytes, active copies and readback.
module pwm_duty_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DW     = 8,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pair_mode,
  input  logic                         load,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [DW-1:0]                rd_data,
  output logic [NUM_CH-1:0][DW-1:0]    active
);
  localparam int NPAIR = NUM_CH / 2;

  logic [NUM_CH-1:0][DW-1:0] staged_q;
  logic [NPAIR-1:0][DW-1:0]  hold_q;
  logic                      addr_ok;

  assign addr_ok = (wr_addr < AW'(NUM_CH));

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      hold_q   <= '0;
      active   <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en && addr_ok) begin
        if (pair_mode) begin
          if (!wr_addr[0]) begin
            hold_q[wr_addr[AW-1:1]] <= wr_data;
          end else begin
            staged_q[wr_addr]                <= wr_data;
            staged_q[{wr_addr[AW-1:1], 1'b0}] <= hold_q[wr_addr[AW-1:1]];
          end
        end else begin
          staged_q[wr_addr] <= wr_data;
        end
      end
      if (load) active <= staged_q;
      rd_data <= (rd_addr < AW'(NUM_CH)) ? staged_q[rd_addr] : '0;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
// Shared period counter; wrap point depends on the mode.
module pwm_timebase
  import pwm_bank_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  pwm_mode_e     mode,
  output logic [CW-1:0] cnt,
  output logic          load
);
  localparam logic [CW-1:0] LIM_SINGLE = CW'(2 ** DW - 2);
  localparam logic [CW-1:0] LIM_DIV    = CW'(2 ** DW - 1);
  localparam logic [CW-1:0] LIM_PAIR   = CW'(2 ** CW - 2);

  logic [CW-1:0] limit;
  logic          at_end;

  always_comb begin
    case (mode)
      MODE_PAIR: limit = LIM_PAIR;
      MODE_DIV:  limit = LIM_DIV;
      default:   limit = LIM_SINGLE;
    endcase
  end

  assign at_end = (cnt >= limit);
  assign load   = restart | (tick & at_end);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
// Per-channel comparator for the three duty modes.
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 2 * DW,
  parameter bit LEAD = 1'b1
) (
  input  pwm_mode_e     mode,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] duty,
  input  logic [DW-1:0] duty_hi,
  output logic          level
);
  localparam int HW = DW / 2;

  logic [HW-1:0] slot, pos, rev;
  logic          extra;
  logic [HW:0]   span;

  assign slot = cnt[DW-1:HW];
  assign pos  = cnt[HW-1:0];

  always_comb begin
    for (int b = 0; b < HW; b++) rev[b] = slot[HW-1-b];
    extra = (rev < duty[HW-1:0]);
    span  = {1'b0, duty[DW-1:HW]} + {{HW{1'b0}}, extra};
    case (mode)
      MODE_PAIR: level = LEAD ? (cnt < {duty_hi, duty}) : 1'b0;
      MODE_DIV:  level = ({1'b0, pos} < span);
      default:   level = (cnt < {{(CW-DW){1'b0}}, duty});
    endcase
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter  int NUM_CH = 6,
  parameter  int DW     = 8,
  localparam int AW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CW = 2 * DW;

  pwm_mode_e                 mode_in, mode_q;
  logic                      restart, load;
  logic [CW-1:0]             cnt;
  logic [NUM_CH-1:0][DW-1:0] active, hi_byte;
  logic [NUM_CH-1:0]         level;

  assign mode_in = pwm_mode_e'(mode);
  assign restart = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SINGLE;
    else     mode_q <= mode_in;
  end

  pwm_duty_regs #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .pair_mode(mode_q == MODE_PAIR), .load(load),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .active(active)
  );

  pwm_timebase #(.DW(DW), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .mode(mode_q), .cnt(cnt), .load(load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i % 2 == 0) begin : g_lead
      assign hi_byte[i] = active[i+1];
    end else begin : g_follow
      assign hi_byte[i] = active[i];
    end
    pwm_chan #(.DW(DW), .CW(CW), .LEAD(i % 2 == 0)) u_chan (
      .mode(mode_q), .cnt(cnt), .duty(active[i]),
      .duty_hi(hi_byte[i]), .level(level[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pwm_out <= '0;
    else if (tick)      pwm_out <= level;
  end
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker #(
  parameter int NUM_CH = 6,
  parameter int DW     = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic [1:0]            mode,
  input logic [1:0]            mode_q,
  input logic [2*DW-1:0]       cnt,
  input logic [NUM_CH-1:0]     pwm_out,
  input logic [DW-1:0]         rd_data
);
  localparam int CW = 2 * DW;

  logic [CW-1:0]     lim;
  logic [NUM_CH-1:0] odd_mask;

  always_comb begin
    case (mode_q)
      2'd1:    lim = CW'(2 ** CW - 2);
      2'd2:    lim = CW'(2 ** DW - 1);
      default: lim = CW'(2 ** DW - 2);
    endcase
    for (int i = 0; i < NUM_CH; i++) odd_mask[i] = (i % 2 == 1);
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pwm_out == '0 && rd_data == '0));

  // Counter never passes the wrap point of the active mode (R3, R4, R5).
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

  assert_odd_low_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1) |-> ((pwm_out & odd_mask) == '0));

  assert_tick_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && mode == mode_q) |=> ($stable(pwm_out) && $stable(cnt)));

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> (cnt == '0 && pwm_out == '0));
endmodule

bind pwm_bank pwm_bank_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode(mode), .mode_q(mode_q),
  .cnt(cnt), .pwm_out(pwm_out), .rd_data(rd_data)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 6;
  localparam int NVEC   = 10;
  // {mode, duty for channel 0, expected high ticks per period}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 8'd0},   {2'd0, 8'h01, 8'd1},   {2'd0, 8'h80, 8'd128},
    {2'd0, 8'hFE, 8'd254}, {2'd0, 8'hFF, 8'd255}, {2'd2, 8'h00, 8'd0},
    {2'd2, 8'h53, 8'd83},  {2'd2, 8'hF0, 8'd240}, {2'd2, 8'h0F, 8'd15},
    {2'd2, 8'hFF, 8'd255}
  };

  logic clk = 0, rst = 1, tick = 1, wr_en = 0;
  logic [1:0] mode = 2'd0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0, errors = 0;
  int hc [NUM_CH];

  pwm_bank u_pwm_bank (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); rd_addr = 3'(a);
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  // Leaves the bench one negedge before the sample of count 0.
  task automatic restart_into(input int m);
    @(negedge clk); mode = (m == 0) ? 2'd2 : 2'd0;
    @(negedge clk); mode = 2'(m);
    @(negedge clk);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < NUM_CH; c++) hc[c] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) hc[c] += int'(pwm_out[c]);
    end
  endtask

  function automatic int exp_highs(int m, int v);
    return (m == 2) ? 16 * (v >> 4) + (v & 15) : v;
  endfunction

  function automatic int rev4(int s);
    return ((s & 1) << 3) | ((s & 2) << 1) | ((s & 4) >> 1) | ((s & 8) >> 3);
  endfunction

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 reset pwm_out", pwm_out, 0);
    for (int a = 0; a < NUM_CH; a++) rd(a, 0, "R1 reset register");

    // R2 R3 R5 R9: vector table, pending writes loaded at each restart
    for (int i = 0; i < NVEC; i++) begin
      int m, v, e;
      m = VEC[i][17:16]; v = VEC[i][15:8]; e = VEC[i][7:0];
      wr(0, v); wr(3, 255 - v);
      restart_into(m);
      measure(m == 2 ? 256 : 255);
      chk(m == 2 ? "R5 R2 ch0 highs" : "R3 R2 ch0 highs", hc[0], e);
      chk(m == 2 ? "R5 ch3 highs" : "R3 ch3 highs", hc[3], exp_highs(m, 255 - v));
    end

    // R5: per-slot spreading of extra ticks for 0x53
    wr(0, 8'h53);
    restart_into(2);
    for (int s = 0; s < 16; s++) begin
      measure(16);
      chk($sformatf("R5 slot %0d", s), hc[0], 5 + ((rev4(s) < 3) ? 1 : 0));
    end

    // R8: tick low freezes outputs
    repeat (7) @(negedge clk);
    begin
      logic [NUM_CH-1:0] ref_out;
      int moved;
      tick = 0; moved = 0;
      @(negedge clk); ref_out = pwm_out;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (pwm_out != ref_out) moved++;
      end
      chk("R8 outputs moved while tick low", moved, 0);
      tick = 1;
    end

    // R6: mid-period write waits for the period boundary
    wr(1, 5);
    restart_into(0);
    repeat (20) @(negedge clk);
    wr(1, 200);
    measure(150);
    chk("R6 old duty kept in current period", hc[1], 0);
    repeat (100) @(negedge clk);
    measure(255);
    chk("R6 new duty after boundary", hc[1], 200);

    // R9: restart drives outputs low for one clock
    wr(0, 255);
    restart_into(0);
    repeat (3) @(negedge clk);
    chk("R9 ch0 high before mode change", pwm_out[0], 1);
    mode = 2'd2;
    @(negedge clk);
    chk("R9 restart cycle low", pwm_out[0], 0);
    @(negedge clk);
    chk("R9 count 0 output after restart", pwm_out[0], 1);

    // R4: paired 16-bit mode
    wr(0, 8'h02); wr(1, 8'h01);
    wr(2, 8'hFF); wr(3, 8'hFF);
    wr(4, 8'h80); wr(5, 8'h00);
    restart_into(1);
    measure(65535);
    chk("R4 pair0 highs", hc[0], 258);
    chk("R4 pair1 highs", hc[2], 65535);
    chk("R4 pair2 highs", hc[4], 128);
    chk("R4 odd outputs", hc[1] + hc[3] + hc[5], 0);

    // R7: low byte held until high byte write
    wr(0, 8'hAA);
    rd(0, 8'h02, "R7 low byte not yet committed");
    wr(1, 8'h55);
    rd(0, 8'hAA, "R7 low byte committed");
    rd(1, 8'h55, "R7 high byte committed");

    // R1: out-of-range addresses
    wr(6, 8'h77);
    rd(6, 0, "R1 address 6 reads zero");
    rd(4, 8'h80, "R1 reg 4 unchanged");
    rd(5, 8'h00, "R1 reg 5 unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule